// File: doc/BRIEF.md
# NAND Bus Cycle Timing Generator

This block converts single access requests into timed NAND flash bus strobes. The request can be a command, an address, a data write or a data read. A requester presents an access type and a data value, holds `reqValid`, and waits for the one-cycle `reqAck`. While the access is in progress the block drives the command-latch and address-latch enables, the active-low write and read strobes, and the output enable for the shared data bus. For a read, it also captures the byte or halfword that the flash returns.

Each access runs through three phases. The latch-setup phase lasts as many clocks as the setup field holds, and a value of zero skips it. The strobe phase lasts the strobe field plus one clocks. The hold phase lasts the hold field plus one clocks. All three fields and the bus-width select come from one configuration word, and the block latches them when it accepts a request. A global enable gates acceptance. A separate configuration bit drives the active-low chip enable straight through. Command sequencing, ECC and ready/busy tracking belong to the surrounding logic.

Top module: `nand_cycle_gen`

## Requirements
- R1: While reset is asserted, `nandCle`, `nandAle`, `busOe` and `reqAck` are 0, `nandWeN` and `nandReN` are 1, and `rdData` is 0.
- R2: The setup field is `cfgWord[14:12]`. After acceptance, the strobe stays high for exactly that many cycles; when the field is 0 the strobe phase follows acceptance at once.
- R3: The strobe field is `cfgWord[10:8]`. The strobe phase lasts that value plus one cycles. `nandWeN` is low during it for types 0 (command), 1 (address) and 2 (write). `nandReN` is low during it for type 3 (read). The other strobe stays high for the whole access.
- R4: The hold field is `cfgWord[6:4]`. After the strobe rises, the access continues for that value plus one cycles, and `reqAck` is high in the last of them.
- R5: `nandCle` is high for the whole of a type-0 access and `nandAle` for the whole of a type-1 access. Neither is high for any other type.
- R6: On a read, `rdData` takes the `busIn` value present on the clock edge that ends the strobe phase, and keeps it after the access.
- R7: `busOe` is high for the whole of a type-0, 1 or 2 access and never high during a read.
- R8: `cfgWord[0]` selects bus width: 1 is 16-bit; 0 is 8-bit, in which `busOut[15:8]` and `rdData[15:8]` read 0. While the strobe is low, `busOut` carries the request data.
- R9: `reqAck` lasts one cycle and is followed by one idle cycle. A request held through the acknowledge begins its first phase in the cycle after that idle cycle.
- R10: While `enable` is 0, no request is accepted: strobes, latch enables and `busOe` stay inactive and `reqAck` stays 0.
- R11: `nandCeN` follows the `ceReg` input.
- R12: With setup 0, strobe field 6 and hold field 0, the access has no setup cycle, a 7-cycle strobe and a 1-cycle hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Permits bus cycles |
| ceReg | input | 1 | Level driven onto the chip enable |
| cfgWord | input | 16 | Timing fields and bus width select |
| reqValid | input | 1 | Request present, held until acknowledge |
| reqType | input | 2 | 0 command, 1 address, 2 write, 3 read |
| reqData | input | 16 | Byte or halfword to drive |
| reqAck | output | 1 | One-cycle pulse in the last hold cycle |
| rdData | output | 16 | Captured read value |
| nandCeN | output | 1 | Active-low chip enable |
| nandCle | output | 1 | Command latch enable |
| nandAle | output | 1 | Address latch enable |
| nandWeN | output | 1 | Active-low write strobe |
| nandReN | output | 1 | Active-low read strobe |
| busOe | output | 1 | Data bus output enable |
| busOut | output | 16 | Data driven to the bus |
| busIn | input | 16 | Data returned by the bus |

## Verification
The block samples a request on the edge after `reqValid` rises. The strobe therefore falls in cycle setup+1 counted from that edge, stays low for strobe+1 cycles, and `reqAck` comes hold+1 cycles after the strobe rises. The bench samples every cycle at the falling clock edge and computes those indices from the three fields. It sweeps all 512 field combinations against every access type and both widths. To pin the read capture edge, `busIn` changes to the expected value only for the edge that ends the strobe phase and is scrambled before and after it. `rdData` is then compared once the acknowledge has arrived.

// File: rtl/nandcyc_pkg.sv
package nandcyc_pkg;

  localparam int CFG_W          = 16;
  localparam int CFG_SETUP_LSB  = 12;
  localparam int CFG_ACTIVE_LSB = 8;
  localparam int CFG_HOLD_LSB   = 4;
  localparam int CFG_WIDE_BIT   = 0;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_ACTIVE = 2'd2,
    PH_HOLD   = 2'd3
  } phase_e;

  typedef enum logic [1:0] {
    ACC_CMD   = 2'd0,
    ACC_ADDR  = 2'd1,
    ACC_WRITE = 2'd2,
    ACC_READ  = 2'd3
  } access_e;

  typedef struct packed {
    logic   load;
    logic   capture;
    phase_e phase;
  } ctrl_strobe_t;

endpackage

// File: rtl/nandcyc_ctrl.sv
module nandcyc_ctrl
  import nandcyc_pkg::*;
#(
  parameter int FIELD_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic               reqValid,
  input  logic [FIELD_W-1:0] setupLen,
  input  logic [FIELD_W-1:0] activeLen,
  input  logic [FIELD_W-1:0] holdLen,
  output ctrl_strobe_t       strobe,
  output logic               reqAck
);

  phase_e             phaseQ;
  logic [FIELD_W-1:0] cntQ;
  logic [FIELD_W-1:0] actLenQ;
  logic [FIELD_W-1:0] holdLenQ;
  logic               accept;
  logic               cntDone;

  assign accept  = (phaseQ == PH_IDLE) && reqValid && enable;
  assign cntDone = (cntQ == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phaseQ   <= PH_IDLE;
      cntQ     <= '0;
      actLenQ  <= '0;
      holdLenQ <= '0;
    end else begin
      unique case (phaseQ)
        PH_IDLE: begin
          if (accept) begin
            actLenQ  <= activeLen;
            holdLenQ <= holdLen;
            if (setupLen != '0) begin
              phaseQ <= PH_SETUP;
              cntQ   <= setupLen - FIELD_W'(1);
            end else begin
              phaseQ <= PH_ACTIVE;
              cntQ   <= activeLen;
            end
          end
        end
        PH_SETUP: begin
          if (cntDone) begin
            phaseQ <= PH_ACTIVE;
            cntQ   <= actLenQ;
          end else begin
            cntQ <= cntQ - FIELD_W'(1);
          end
        end
        PH_ACTIVE: begin
          if (cntDone) begin
            phaseQ <= PH_HOLD;
            cntQ   <= holdLenQ;
          end else begin
            cntQ <= cntQ - FIELD_W'(1);
          end
        end
        PH_HOLD: begin
          if (cntDone) begin
            phaseQ <= PH_IDLE;
          end else begin
            cntQ <= cntQ - FIELD_W'(1);
          end
        end
        default: phaseQ <= PH_IDLE;
      endcase
    end
  end

  assign strobe.load    = accept;
  assign strobe.capture = (phaseQ == PH_ACTIVE) && cntDone;
  assign strobe.phase   = phaseQ;
  assign reqAck         = (phaseQ == PH_HOLD) && cntDone;

  // R9: acknowledge is a single pulse and the block is idle afterwards
  p_ack_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    reqAck |=> !reqAck);
  p_ack_then_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    reqAck |=> (strobe.phase == PH_IDLE));
  // R10: a disabled block never leaves idle
  p_disabled_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.phase == PH_IDLE && !enable) |=> (strobe.phase == PH_IDLE));
  // R2: setup only leads to more setup or the strobe phase
  p_setup_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.phase == PH_SETUP) |=> (strobe.phase inside {PH_SETUP, PH_ACTIVE}));
  // R6: capture happens on the last strobe cycle, hold follows
  p_capture_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.capture |=> (strobe.phase == PH_HOLD));

endmodule

// File: rtl/nandcyc_dpath.sv
module nandcyc_dpath
  import nandcyc_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrl_strobe_t      strobe,
  input  logic [1:0]        reqType,
  input  logic [DATA_W-1:0] reqData,
  input  logic              wide,
  input  logic [DATA_W-1:0] busIn,
  output logic              nandCle,
  output logic              nandAle,
  output logic              nandWeN,
  output logic              nandReN,
  output logic              busOe,
  output logic [DATA_W-1:0] busOut,
  output logic [DATA_W-1:0] rdData
);

  localparam int HALF_W = DATA_W / 2;

  access_e           typeQ;
  logic [DATA_W-1:0] dataQ;
  logic              wideQ;
  logic              busy;
  logic              strobeLow;
  logic [DATA_W-1:0] outMasked;
  logic [DATA_W-1:0] inMasked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      typeQ <= ACC_CMD;
      dataQ <= '0;
      wideQ <= 1'b0;
    end else if (strobe.load) begin
      typeQ <= access_e'(reqType);
      dataQ <= reqData;
      wideQ <= wide;
    end
  end

  generate
    if (HALF_W > 0) begin : g_width
      assign outMasked = wideQ ? dataQ : {{(DATA_W-HALF_W){1'b0}}, dataQ[HALF_W-1:0]};
      assign inMasked  = wideQ ? busIn : {{(DATA_W-HALF_W){1'b0}}, busIn[HALF_W-1:0]};
    end else begin : g_narrow
      assign outMasked = dataQ;
      assign inMasked  = busIn;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdData <= '0;
    end else if (strobe.capture && typeQ == ACC_READ) begin
      rdData <= inMasked;
    end
  end

  assign busy      = (strobe.phase != PH_IDLE);
  assign strobeLow = (strobe.phase == PH_ACTIVE);
  assign nandCle   = busy && (typeQ == ACC_CMD);
  assign nandAle   = busy && (typeQ == ACC_ADDR);
  assign nandWeN   = !(strobeLow && typeQ != ACC_READ);
  assign nandReN   = !(strobeLow && typeQ == ACC_READ);
  assign busOe     = busy && (typeQ != ACC_READ);
  assign busOut    = busOe ? outMasked : '0;

  // R5: latch enables are exclusive and steady through an access
  p_latch_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(nandCle && nandAle));
  p_cle_steady_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(nandCle) && $stable(nandAle)));
  // R3: never both strobes low
  p_strobe_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(!nandWeN && !nandReN));
  // R7: bus is not driven while reading
  p_no_oe_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(busOe && !nandReN));

endmodule

// File: rtl/nand_cycle_gen.sv
module nand_cycle_gen
  import nandcyc_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int FIELD_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              ceReg,
  input  logic [CFG_W-1:0]  cfgWord,
  input  logic              reqValid,
  input  logic [1:0]        reqType,
  input  logic [DATA_W-1:0] reqData,
  output logic              reqAck,
  output logic [DATA_W-1:0] rdData,
  output logic              nandCeN,
  output logic              nandCle,
  output logic              nandAle,
  output logic              nandWeN,
  output logic              nandReN,
  output logic              busOe,
  output logic [DATA_W-1:0] busOut,
  input  logic [DATA_W-1:0] busIn
);

  ctrl_strobe_t       strobe;
  logic [FIELD_W-1:0] setupLen;
  logic [FIELD_W-1:0] activeLen;
  logic [FIELD_W-1:0] holdLen;

  assign setupLen  = cfgWord[CFG_SETUP_LSB  +: FIELD_W];
  assign activeLen = cfgWord[CFG_ACTIVE_LSB +: FIELD_W];
  assign holdLen   = cfgWord[CFG_HOLD_LSB   +: FIELD_W];
  assign nandCeN   = ceReg;

  nandcyc_ctrl #(.FIELD_W(FIELD_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .reqValid  (reqValid),
    .setupLen  (setupLen),
    .activeLen (activeLen),
    .holdLen   (holdLen),
    .strobe    (strobe),
    .reqAck    (reqAck)
  );

  nandcyc_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobe  (strobe),
    .reqType (reqType),
    .reqData (reqData),
    .wide    (cfgWord[CFG_WIDE_BIT]),
    .busIn   (busIn),
    .nandCle (nandCle),
    .nandAle (nandAle),
    .nandWeN (nandWeN),
    .nandReN (nandReN),
    .busOe   (busOe),
    .busOut  (busOut),
    .rdData  (rdData)
  );

endmodule

// File: tb/nand_cycle_gen_bench.sv
`timescale 1ns/1ps
module nand_cycle_gen_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b1;
  logic        ceReg = 1'b1;
  logic [15:0] cfgWord = '0;
  logic        reqValid = 1'b0;
  logic [1:0]  reqType = '0;
  logic [15:0] reqData = '0;
  logic        reqAck;
  logic [15:0] rdData;
  logic        nandCeN, nandCle, nandAle, nandWeN, nandReN, busOe;
  logic [15:0] busOut;
  logic [15:0] busIn = '0;

  int total = 0;
  int bad = 0;
  int lastFirst, lastLowCnt, lastHold;

  always #2 clk = ~clk;

  nand_cycle_gen u_nand_cycle_gen (
    .clk(clk), .rst_n(rst_n), .enable(enable), .ceReg(ceReg),
    .cfgWord(cfgWord), .reqValid(reqValid), .reqType(reqType),
    .reqData(reqData), .reqAck(reqAck), .rdData(rdData),
    .nandCeN(nandCeN), .nandCle(nandCle), .nandAle(nandAle),
    .nandWeN(nandWeN), .nandReN(nandReN), .busOe(busOe),
    .busOut(busOut), .busIn(busIn)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic runTxn(input int ts, input int tw0, input int tw1, input int ty,
                        input logic wide, input logic [15:0] d, input bit keep);
    int idx = 0, firstLow = 0, lowCnt = 0, lastLow = 0, ackIdx = 0;
    bit okCle = 1, okOe = 1, okOut = 1, okOther = 1;
    logic [15:0] readVal = d ^ 16'h5AA5;
    logic [15:0] expOut = wide ? d : {8'h00, d[7:0]};
    logic [15:0] expRd = wide ? readVal : {8'h00, readVal[7:0]};
    logic strb, other;
    cfgWord  = {1'b0, 3'(ts), 1'b0, 3'(tw0), 1'b0, 3'(tw1), 3'b000, wide};
    reqType  = 2'(ty);
    reqData  = d;
    busIn    = ~readVal;
    reqValid = 1'b1;
    while (ackIdx == 0 && idx < 40) begin
      cyc();
      idx++;
      strb  = (ty == 3) ? nandReN : nandWeN;
      other = (ty == 3) ? nandWeN : nandReN;
      if (!strb) begin
        if (firstLow == 0) firstLow = idx;
        lowCnt++;
        lastLow = idx;
        if (ty != 3 && busOut != expOut) okOut = 0;
      end
      if (!other) okOther = 0;
      if (nandCle != (ty == 0) || nandAle != (ty == 1)) okCle = 0;
      if (busOe != (ty != 3)) okOe = 0;
      if (reqAck) ackIdx = idx;
      busIn = (idx == ts + tw0 + 1) ? readVal : ~readVal;
    end
    if (!keep) reqValid = 1'b0;
    lastFirst = firstLow; lastLowCnt = lowCnt; lastHold = ackIdx - lastLow;
    chk(firstLow == ts + 1, "R2 setup", firstLow, ts + 1);
    chk(lowCnt == tw0 + 1, "R3 strobe", lowCnt, tw0 + 1);
    chk(okOther, "R3 other strobe", 0, 1);
    chk(ackIdx - lastLow == tw1 + 1, "R4 hold", ackIdx - lastLow, tw1 + 1);
    chk(okCle, "R5 latch enables", 0, 1);
    chk(okOe, "R7 output enable", 0, 1);
    if (ty != 3) chk(okOut, "R8 busOut", 0, 1);
    else chk(rdData == expRd, "R6/R8 rdData", rdData, expRd);
    if (!keep) begin
      cyc();
      chk(!reqAck && nandWeN && nandReN && !busOe && !nandCle && !nandAle,
          "R9 idle after ack", reqAck, 0);
    end
  endtask

  initial begin
    #(190000 * 4);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (3) cyc();
    chk(!nandCle && !nandAle && nandWeN && nandReN && !busOe && !reqAck && rdData == 0,
        "R1 reset outputs", {nandCle, nandAle, nandWeN, nandReN, busOe, reqAck}, 6'b001100);
    rst_n = 1'b1;
    cyc();

    // R11 chip enable follows its input
    ceReg = 1'b0; #1;
    chk(nandCeN == 1'b0, "R11 ce low", nandCeN, 0);
    ceReg = 1'b1; #1;
    chk(nandCeN == 1'b1, "R11 ce high", nandCeN, 1);
    ceReg = 1'b0;
    cyc();

    // R12 example timing
    runTxn(0, 6, 0, 2, 1'b0, 16'hA1B2, 1'b0);
    chk(lastFirst == 1 && lastLowCnt == 7 && lastHold == 1, "R12 0/6/0 timing",
        {lastFirst, lastLowCnt, lastHold}, {32'd1, 32'd7, 32'd1});

    // Exhaustive sweep of all timing fields, types and widths
    for (int ts = 0; ts < 8; ts++)
      for (int a = 0; a < 8; a++)
        for (int h = 0; h < 8; h++)
          for (int ty = 0; ty < 4; ty++)
            runTxn(ts, a, h, ty, 1'((ts + a + h + ty) % 2),
                   16'(ts * 4099 + a * 613 + h * 97 + ty * 31 + 16'h1234), 1'b0);

    // R9 back-to-back: request held across the acknowledge
    runTxn(2, 1, 1, 0, 1'b1, 16'h0070, 1'b1);
    cfgWord = {1'b0, 3'd0, 1'b0, 3'd0, 1'b0, 3'd0, 3'b000, 1'b1};
    reqType = 2'd2;
    reqData = 16'hBEEF;
    cyc();
    chk(nandWeN && !busOe && !reqAck, "R9 idle gap", nandWeN, 1);
    cyc();
    chk(!nandWeN && busOut == 16'hBEEF, "R9 next accepted", nandWeN, 0);
    reqValid = 1'b0;
    cyc();
    chk(reqAck, "R9 next ack", reqAck, 1);
    cyc();

    // R10 disabled block ignores requests
    enable = 1'b0;
    reqType = 2'd0;
    reqValid = 1'b1;
    begin
      bit quiet = 1;
      for (int i = 0; i < 12; i++) begin
        cyc();
        if (!nandWeN || !nandReN || nandCle || nandAle || busOe || reqAck) quiet = 0;
      end
      chk(quiet, "R10 disabled quiet", 0, 1);
    end
    reqValid = 1'b0;
    enable = 1'b1;
    cyc();
    runTxn(1, 1, 1, 3, 1'b1, 16'h4321, 1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule